// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address stream for a single read or write burst into one open row of a synchronous DRAM. A one-cycle start pulse loads an 8-bit starting column together with an already decoded burst length code and an ordering select. From the next clock on, the block presents one column address per cycle with a valid flag, and it raises a last-beat flag on the final address of a fixed-length burst.

Fixed-length bursts stay inside an aligned window whose size is the burst length. The ordering is either counting upward with wrap inside that window or XOR-ing the beat number into the low bits. A full-page burst walks through every column of the row and wraps from the top back to zero. It continues until a terminate request arrives. A new start can arrive on any cycle and replaces whatever burst is in flight.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_vld` and `col_last` are both 0.
- R2: On the cycle after `start` is sampled high, `col_vld` is 1 and `col` equals `start_col`. The length code and ordering select are captured at start, and changing them during a burst has no effect on that burst.
- R3: A length code of 0, 1, 2 or 3 gives a burst of 1, 2, 4 or 8 beats, one beat per cycle. `col_vld` falls on the cycle after the final beat unless a new start was sampled.
- R4: With `ilv_sel`=0 and a length of N beats, beat k shows the start column with its low log2(N) bits replaced by (low bits + k) mod N. The upper bits keep their start value.
- R5: With `ilv_sel`=1 and a fixed length of N beats, beat k shows the start column XOR k.
- R6: Any length code with bit 2 set selects full page. Beat k shows (start column + k) mod 256, whatever the value of `ilv_sel`, and the burst continues until it is terminated or replaced.
- R7: `col_last` is 1 exactly on the final beat of a fixed-length burst. It is never 1 in full-page mode, and never while `col_vld` is 0.
- R8: If `term` is sampled high while a burst runs and `start` is low, `col_vld` is 0 on the next cycle. `term` while idle has no effect.
- R9: A sampled `start` replaces a burst in progress and takes priority over a `term` sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst this cycle |
| start_col | input | COL_W | First column of the burst |
| len_sel | input | 3 | Length code: 0..3 give 2^code beats, bit 2 set selects full page |
| ilv_sel | input | 1 | 1 selects interleaved ordering for fixed lengths |
| term | input | 1 | Stop the running burst after this cycle |
| col | output | COL_W | Current column address |
| col_vld | output | 1 | `col` holds a beat of the burst |
| col_last | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench builds the block with its default `COL_W` of 8, so a whole row of 256 columns is addressable. This lets a full-page burst started near column 255 be seen wrapping through zero. Unaligned start columns under every fixed length expose window wrap in both orderings. Short terminations, a start that overlaps a running burst and a start coinciding with a terminate reach the priority corners.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int LG_W = 2;

  typedef struct packed {
    logic [LG_W-1:0] lg;    // log2 of fixed burst length
    logic            full;  // full-page burst
    logic            ilv;   // interleaved ordering
  } bcg_cfg_t;

  // Split the 3-bit length code and the ordering select into a config word.
  function automatic bcg_cfg_t decode_cfg(input logic [2:0] code, input logic ilv_in);
    bcg_cfg_t c;
    c.lg   = code[LG_W-1:0];
    c.full = code[2];
    c.ilv  = ilv_in & ~code[2];
    return c;
  endfunction

endpackage

// File: rtl/bcg_seq_ctrl.sv
module bcg_seq_ctrl
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  bcg_cfg_t         cfg_in,
  input  logic             term,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] beat_q,
  output bcg_cfg_t         cfg_q,
  output logic             vld_q,
  output logic             last_beat
);

  // Index of the final beat for a fixed-length burst.
  function automatic logic [COL_W-1:0] final_idx(input logic [LG_W-1:0] lg);
    return (COL_W'(1) << lg) - COL_W'(1);
  endfunction

  logic term_hit;
  logic burst_done;

  assign last_beat  = vld_q & ~cfg_q.full & (beat_q == final_idx(cfg_q.lg));
  assign term_hit   = vld_q & term & ~start;
  assign burst_done = last_beat & ~start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      cfg_q  <= '0;
      vld_q  <= 1'b0;
    end else if (start) begin
      base_q <= start_col;
      beat_q <= '0;
      cfg_q  <= cfg_in;
      vld_q  <= 1'b1;
    end else if (term_hit || burst_done) begin
      vld_q  <= 1'b0;
    end else if (vld_q) begin
      beat_q <= beat_q + COL_W'(1);
    end
  end

  AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |=> !vld_q); // R8

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !vld_q); // R3

  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && cfg_q.full) |-> !last_beat); // R7

  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (vld_q && beat_q == '0)); // R9

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  bcg_cfg_t         cfg,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] sum;
  assign sum = base + beat;

  // Per bit: full page follows the sum; inside the window the bit follows the
  // sum (carries only move upward) or base^beat; above the window it holds.
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    logic in_win;
    assign in_win = (i < int'(cfg.lg));
    always_comb begin
      if (cfg.full)       col[i] = sum[i];
      else if (!in_win)   col[i] = base[i];
      else if (cfg.ilv)   col[i] = base[i] ^ beat[i];
      else                col[i] = sum[i];
    end
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             ilv_sel,
  input  logic             term,
  output logic [COL_W-1:0] col,
  output logic             col_vld,
  output logic             col_last
);

  bcg_cfg_t         cfg_new;
  bcg_cfg_t         cfg_cur;
  logic [COL_W-1:0] base_cur;
  logic [COL_W-1:0] beat_cur;

  assign cfg_new = decode_cfg(len_sel, ilv_sel);

  bcg_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .cfg_in    (cfg_new),
    .term      (term),
    .base_q    (base_cur),
    .beat_q    (beat_cur),
    .cfg_q     (cfg_cur),
    .vld_q     (col_vld),
    .last_beat (col_last)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base (base_cur),
    .beat (beat_cur),
    .cfg  (cfg_cur),
    .col  (col)
  );

  AST_BEAT0_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_vld && col == $past(start_col))); // R2

  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && cfg_cur.full && !start && !term) |=>
      (col_vld && col == $past(col) + COL_W'(1))); // R6

  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_vld); // R7

endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;

  typedef struct {
    logic [7:0] c;
    logic       l;
    string      tag;
  } beat_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_sel = '0;
  logic       ilv_sel = 1'b0;
  logic       term = 1'b0;
  logic [7:0] col;
  logic       col_vld;
  logic       col_last;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  beat_t exp_q[$];

  always #2.5 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_sel(len_sel), .ilv_sel(ilv_sel), .term(term),
    .col(col), .col_vld(col_vld), .col_last(col_last)
  );

  // Expected column, restated arithmetically from R4, R5, R6.
  function automatic logic [7:0] exp_col(input int base, input int k,
                                          input logic [2:0] code, input logic il);
    int n;
    if (code[2]) return 8'((base + k) % 256);
    n = 1 << code[1:0];
    if (il) return 8'(base ^ k);
    return 8'((base - base % n) + ((base % n + k) % n));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pop and compare every valid beat.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (col_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 extra beat", int'(col), -1);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(col == e.c, e.tag, int'(col), int'(e.c));
          chk(col_last == e.l, "R7", int'(col_last), int'(e.l));
        end
      end else begin
        chk(col_last == 1'b0, "R7 last while idle", int'(col_last), 0);
      end
    end
  end

  task automatic push_beats(input int base, input logic [2:0] code, input logic il,
                            input int cnt);
    int n;
    n = code[2] ? 0 : (1 << code[1:0]);
    for (int k = 0; k < cnt; k++) begin
      beat_t e;
      e.c   = exp_col(base, k, code, il);
      e.l   = !code[2] && (k == n - 1);
      e.tag = code[2] ? "R6" : (il ? "R5" : "R4");
      exp_q.push_back(e);
    end
  endtask

  task automatic tail_check(input string req);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(col_vld == 1'b0, req, int'(col_vld), 0);
  endtask

  // Driver: cut = 0 means no terminate; tws asserts term together with start.
  task automatic burst(input int base, input logic [2:0] code, input logic il,
                       input int cut, input bit tws);
    int n, cnt;
    n = code[2] ? 0 : (1 << code[1:0]);
    if (code[2]) cnt = cut;
    else cnt = (cut > 0 && cut < n) ? cut : n;
    push_beats(base, code, il, cnt);
    @(negedge clk);
    start = 1'b1; start_col = 8'(base); len_sel = code; ilv_sel = il; term = tws;
    @(negedge clk);
    start = 1'b0; term = 1'b0;
    len_sel = ~code; ilv_sel = ~il;   // R2: mid-burst changes ignored
    if (cut > 0 && cut <= cnt) begin
      repeat (cut - 1) @(negedge clk);
      term = 1'b1;                     // R8
      @(negedge clk);
      term = 1'b0;
    end else begin
      repeat (cnt - 1) @(negedge clk);
    end
    tail_check("R3/R8 burst end");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(col_vld == 1'b0 && col_last == 1'b0, "R1 reset", {col_vld, col_last}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(col_vld == 1'b0, "R1 after release", int'(col_vld), 0);

    // R3/R4 sequential, all fixed lengths, unaligned starts
    burst(8'h35, 3'd0, 1'b0, 0, 1'b0);
    burst(8'h35, 3'd1, 1'b0, 0, 1'b0);
    burst(8'h35, 3'd2, 1'b0, 0, 1'b0);
    burst(8'h3D, 3'd3, 1'b0, 0, 1'b0);
    burst(8'hFF, 3'd3, 1'b0, 0, 1'b0);
    // R5 interleaved
    burst(8'h5A, 3'd3, 1'b1, 0, 1'b0);
    burst(8'h5A, 3'd2, 1'b1, 0, 1'b0);
    burst(8'h81, 3'd1, 1'b1, 0, 1'b0);
    // R6 full page wrapping past 255, with and without ilv_sel
    burst(250, 3'd4, 1'b0, 10, 1'b0);
    burst(253, 3'd7, 1'b1, 6, 1'b0);
    // R8 terminate inside a fixed burst, and on its first beat
    burst(8'h20, 3'd3, 1'b0, 3, 1'b0);
    burst(8'h44, 3'd3, 1'b1, 1, 1'b0);
    // R9 start and term on the same edge: start wins
    burst(8'h90, 3'd2, 1'b0, 0, 1'b1);

    // R8 term while idle has no effect
    @(negedge clk);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk(col_vld == 1'b0, "R8 idle term", int'(col_vld), 0);
    @(negedge clk);
    chk(col_vld == 1'b0, "R8 idle term", int'(col_vld), 0);

    // R9 new start replaces a running burst
    push_beats(8'h10, 3'd3, 1'b0, 3);
    push_beats(8'h77, 3'd1, 1'b1, 2);
    @(negedge clk);
    start = 1'b1; start_col = 8'h10; len_sel = 3'd3; ilv_sel = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; start_col = 8'h77; len_sel = 3'd1; ilv_sel = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    tail_check("R9 replace");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule